// File: doc/BRIEF.md
# Table-Coded Audio Clock Divider

This block derives two audio clocks from a single module clock (24.576 MHz in the intended setup). A master clock is produced for an external converter, and a bit clock is produced for the serial audio framer, both as a level and as a one-cycle enable pulse in the module clock domain. Neither ratio is programmed as a raw count. A small code selects one entry from a fixed, non-uniform table of allowed ratios, and that table holds non-power-of-two values such as 6, 12, 48 and 176.

A parameter selects one of two table variants. The default variant uses one 4-bit table for both clocks, and both dividers count module clock cycles. The legacy variant uses a 3-bit bit-clock table and a separate master-clock table. In the legacy variant the bit-clock divider counts master-clock periods rather than module-clock cycles. For 48 kHz stereo with 32-bit slots, the bit clock is 3.072 MHz, which is a divide of 8.

A new code is adopted only when the running period completes. An unsupported code raises an error flag and, once the current period has finished, stops that clock low. A gate input decides whether the master clock reaches its output pin. The frame clock is not generated here; the framer derives it.

Top module: `audclk_divider`

## Requirements
- R1: While rst_n is low at a clock edge, every output is low after that edge: both levels, both ticks and both error flags.
- R2: In the default variant, codes 1 to 15 select these divides: 1, 2, 4, 6, 8, 12, 16, 24, 32, 48, 64, 96, 128, 176, 192. With divide N, the tick of that clock is high for one module clock cycle every N cycles. For example, a bit-clock code of 5 gives a tick every 8 cycles.
- R3: Code 0 is invalid in the default variant. After the current period wraps, the affected clock stops: its level and tick stay low until a valid code is applied.
- R4: In the legacy variant, bit-clock codes 0 to 5 select divides of 2, 4, 6, 8, 12 and 16. Codes 6 to 15 are invalid and stop the bit clock.
- R5: In the legacy variant, master-clock codes 0 to 7 select divides of 1, 2, 4, 6, 8, 12, 16 and 24. Any code with bit 3 set is invalid and stops the master clock.
- R6: In the legacy variant, the bit-clock divider advances only on master-clock ticks. Its period is therefore the product of the two ratios in module cycles: master code 0 with bit code 3 gives 8 cycles, and master code 1 with bit code 3 gives 16 cycles.
- R7: For an even divide N, the level is high for N/2 ticks of its counting clock and then low for N/2. It starts high in the period that begins with a tick.
- R8: For a divide of 1, the level follows the module clock itself, and the tick is high on every enabled cycle.
- R9: A code change takes effect only when the running period completes, so the current period keeps its old length.
- R10: While mclk_gate_en is low, mclk_o is low, and mclk_tick keeps running unchanged.
- R11: Each error flag is high in the cycle after a clock edge at which its code input was invalid, and low in the cycle after an edge at which its code was valid.
- R12: A stopped divider, whether stopped by reset or by an invalid code, starts with a tick at the first counting edge at which a valid code is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock, the source of both derived clocks |
| rst_n | input | 1 | Synchronous active-low reset |
| mclk_code | input | CODE_W | Master-clock ratio code |
| bclk_code | input | CODE_W | Bit-clock ratio code |
| mclk_gate_en | input | 1 | Lets the master clock reach mclk_o |
| mclk_o | output | 1 | Gated master-clock level |
| mclk_tick | output | 1 | One-cycle pulse at each master-clock period start (ungated) |
| bclk_o | output | 1 | Bit-clock level |
| bclk_tick | output | 1 | One-cycle pulse at each bit-clock period start |
| mclk_code_err | output | 1 | Master-clock code is invalid |
| bclk_code_err | output | 1 | Bit-clock code is invalid |

## Verification
The bench builds two copies side by side, one with LEGACY at 0 and one with LEGACY at 1, and drives both from the same clock and reset. The default copy covers the full 4-bit table, including pass-through and the 176 and 192 ratios. The legacy copy covers the separate tables, the cascaded bit-clock count driven by master ticks, and the invalid codes that exist only in the short tables.

// File: rtl/audclk_pkg.sv
`timescale 1ns/1ps
// Shared types and ratio tables for the audio clock divider.
// Assumes codes are at most 4 bits and ratios fit in 8 bits.
package audclk_pkg;

    localparam int PKG_CODE_W  = 4;
    localparam int PKG_RATIO_W = 8;

    // Which ratio table a lookup instance implements
    typedef enum logic [1:0] {
        TBL_UNIFIED  = 2'd0,
        TBL_LEG_BCLK = 2'd1,
        TBL_LEG_MCLK = 2'd2
    } ratio_tbl_e;

    // Map a code to its divide ratio; 0 means the code is not allowed
    function automatic logic [PKG_RATIO_W-1:0] ratio_of(ratio_tbl_e tbl,
                                                        logic [PKG_CODE_W-1:0] code);
        logic [PKG_RATIO_W-1:0] r;
        r = '0;
        case (tbl)
            TBL_UNIFIED: begin
                case (code)
                    4'd1:  r = 8'd1;
                    4'd2:  r = 8'd2;
                    4'd3:  r = 8'd4;
                    4'd4:  r = 8'd6;
                    4'd5:  r = 8'd8;
                    4'd6:  r = 8'd12;
                    4'd7:  r = 8'd16;
                    4'd8:  r = 8'd24;
                    4'd9:  r = 8'd32;
                    4'd10: r = 8'd48;
                    4'd11: r = 8'd64;
                    4'd12: r = 8'd96;
                    4'd13: r = 8'd128;
                    4'd14: r = 8'd176;
                    4'd15: r = 8'd192;
                    default: r = 8'd0;
                endcase
            end
            TBL_LEG_BCLK: begin
                case (code)
                    4'd0: r = 8'd2;
                    4'd1: r = 8'd4;
                    4'd2: r = 8'd6;
                    4'd3: r = 8'd8;
                    4'd4: r = 8'd12;
                    4'd5: r = 8'd16;
                    default: r = 8'd0;
                endcase
            end
            TBL_LEG_MCLK: begin
                case (code)
                    4'd0: r = 8'd1;
                    4'd1: r = 8'd2;
                    4'd2: r = 8'd4;
                    4'd3: r = 8'd6;
                    4'd4: r = 8'd8;
                    4'd5: r = 8'd12;
                    4'd6: r = 8'd16;
                    4'd7: r = 8'd24;
                    default: r = 8'd0;
                endcase
            end
            default: r = 8'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/audclk_ratio_lut.sv
`timescale 1ns/1ps
// Combinational code-to-ratio decoder for one table variant.
// Assumes CODE_W <= 4 and RATIO_W >= 8; a zero ratio marks an invalid code.
module audclk_ratio_lut
    import audclk_pkg::*;
#(
    parameter ratio_tbl_e TBL     = TBL_UNIFIED,
    parameter int         CODE_W  = PKG_CODE_W,
    parameter int         RATIO_W = PKG_RATIO_W
) (
    input  logic [CODE_W-1:0]  code,
    output logic [RATIO_W-1:0] ratio
);

    logic [PKG_CODE_W-1:0] code_ext;

    // Widen or trim the code to the table index width
    always_comb code_ext = PKG_CODE_W'(code);

    // Look up the ratio in the selected table
    always_comb ratio = RATIO_W'(ratio_of(TBL, code_ext));

endmodule

// File: rtl/audclk_div_core.sv
`timescale 1ns/1ps
// Ratio-driven clock divider stage.
// Counts enabled cycles 0..ratio-1, with the level high for the first half.
// A requested ratio is adopted only at a wrap or from the stopped state;
// a zero request stops the stage low. A ratio of 1 passes clk through.
// Assumes ratios other than 1 are even.
module audclk_div_core #(
    parameter int RATIO_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cnt_en,
    input  logic [RATIO_W-1:0] ratio_req,
    output logic               level_o,
    output logic               tick_o,
    output logic               err_o
);

    localparam logic [RATIO_W-1:0] ONE = RATIO_W'(1);

    logic [RATIO_W-1:0] ratio_q;
    logic [RATIO_W-1:0] cnt_q;
    logic               run_q;
    logic               err_q;
    logic               req_ok;
    logic               at_wrap;
    logic               half_hi;

    // Request validity and end-of-period detection
    always_comb begin
        req_ok  = (ratio_req != '0);
        at_wrap = (cnt_q == ratio_q - ONE);
        half_hi = (cnt_q < (ratio_q >> 1));
    end

    // Period counter with ratio adoption at the wrap point
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q   <= 1'b0;
            ratio_q <= '0;
            cnt_q   <= '0;
        end else if (cnt_en) begin
            if (!run_q || at_wrap) begin
                cnt_q <= '0;
                if (req_ok) begin
                    run_q   <= 1'b1;
                    ratio_q <= ratio_req;
                end else begin
                    run_q   <= 1'b0;
                    ratio_q <= '0;
                end
            end else begin
                cnt_q <= cnt_q + ONE;
            end
        end
    end

    // Registered invalid-code flag
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= !req_ok;
    end

    // Output level, period-start pulse and error flag
    always_comb begin
        if (run_q && ratio_q == ONE) level_o = clk;
        else                         level_o = run_q && half_hi;
        tick_o = run_q && cnt_en && (cnt_q == '0);
        err_o  = err_q;
    end

endmodule

// File: rtl/audclk_divider.sv
`timescale 1ns/1ps
// Audio clock divider top: master clock and bit clock from the module clock.
// LEGACY=0: one shared 4-bit table, both stages count module cycles.
// LEGACY=1: separate short tables, and the bit-clock stage counts
//           master-clock ticks. The gate masks only the master-clock pin.
module audclk_divider
    import audclk_pkg::*;
#(
    parameter bit LEGACY  = 1'b0,
    parameter int CODE_W  = PKG_CODE_W,
    parameter int RATIO_W = PKG_RATIO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] mclk_code,
    input  logic [CODE_W-1:0] bclk_code,
    input  logic              mclk_gate_en,
    output logic              mclk_o,
    output logic              mclk_tick,
    output logic              bclk_o,
    output logic              bclk_tick,
    output logic              mclk_code_err,
    output logic              bclk_code_err
);

    localparam ratio_tbl_e MCLK_TBL = LEGACY ? TBL_LEG_MCLK : TBL_UNIFIED;
    localparam ratio_tbl_e BCLK_TBL = LEGACY ? TBL_LEG_BCLK : TBL_UNIFIED;

    logic [RATIO_W-1:0] m_ratio;
    logic [RATIO_W-1:0] b_ratio;
    logic               m_level;
    logic               m_tick;
    logic               b_en;

    audclk_ratio_lut #(.TBL(MCLK_TBL), .CODE_W(CODE_W), .RATIO_W(RATIO_W)) i_mclk_lut (
        .code  (mclk_code),
        .ratio (m_ratio)
    );

    audclk_ratio_lut #(.TBL(BCLK_TBL), .CODE_W(CODE_W), .RATIO_W(RATIO_W)) i_bclk_lut (
        .code  (bclk_code),
        .ratio (b_ratio)
    );

    audclk_div_core #(.RATIO_W(RATIO_W)) i_mclk_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (1'b1),
        .ratio_req (m_ratio),
        .level_o   (m_level),
        .tick_o    (m_tick),
        .err_o     (mclk_code_err)
    );

    // Bit-clock count source: master ticks (legacy) or every module cycle
    generate
        if (LEGACY) begin : g_cascade
            always_comb b_en = m_tick;
        end else begin : g_direct
            always_comb b_en = 1'b1;
        end
    endgenerate

    audclk_div_core #(.RATIO_W(RATIO_W)) i_bclk_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_en    (b_en),
        .ratio_req (b_ratio),
        .level_o   (bclk_o),
        .tick_o    (bclk_tick),
        .err_o     (bclk_code_err)
    );

    // Gate the master clock onto its pin; the tick stays ungated
    always_comb begin
        mclk_o    = mclk_gate_en && m_level;
        mclk_tick = m_tick;
    end

endmodule

// File: rtl/audclk_divider_chk.sv
`timescale 1ns/1ps
// Property checker for audclk_divider, attached with bind below.
module audclk_divider_chk
    import audclk_pkg::*;
#(
    parameter bit LEGACY = 1'b0,
    parameter int CODE_W = PKG_CODE_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CODE_W-1:0] mclk_code,
    input logic [CODE_W-1:0] bclk_code,
    input logic              mclk_gate_en,
    input logic              mclk_o,
    input logic              mclk_tick,
    input logic              bclk_o,
    input logic              bclk_tick,
    input logic              mclk_code_err,
    input logic              bclk_code_err
);

    localparam ratio_tbl_e MT = LEGACY ? TBL_LEG_MCLK : TBL_UNIFIED;
    localparam ratio_tbl_e BT = LEGACY ? TBL_LEG_BCLK : TBL_UNIFIED;

    // R1
    reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!mclk_tick && !bclk_tick && !mclk_code_err && !bclk_code_err));

    // R10
    gate_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mclk_gate_en |-> !mclk_o);

    // R11
    mclk_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (mclk_code_err == (ratio_of(MT, PKG_CODE_W'($past(mclk_code))) == '0)));

    // R11
    bclk_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (bclk_code_err == (ratio_of(BT, PKG_CODE_W'($past(bclk_code))) == '0)));

    generate
        if (LEGACY) begin : g_leg
            // R6
            cascade_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
                bclk_tick |-> mclk_tick);
        end
    endgenerate

endmodule

bind audclk_divider audclk_divider_chk #(.LEGACY(LEGACY), .CODE_W(CODE_W)) i_chk (.*);

// File: tb/test_audclk_divider.sv
`timescale 1ns/1ps
module test_audclk_divider;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic [3:0] u_mc = 4'd1, u_bc = 4'd5, l_mc = 4'd0, l_bc = 4'd3;
    logic u_gate = 1'b1, l_gate = 1'b1;
    logic u_mo, u_mt, u_bo, u_bt, u_me, u_be;
    logic l_mo, l_mt, l_bo, l_bt, l_me, l_be;

    audclk_divider #(.LEGACY(1'b0)) i_audclk_divider (
        .clk(clk), .rst_n(rst_n), .mclk_code(u_mc), .bclk_code(u_bc),
        .mclk_gate_en(u_gate), .mclk_o(u_mo), .mclk_tick(u_mt),
        .bclk_o(u_bo), .bclk_tick(u_bt), .mclk_code_err(u_me), .bclk_code_err(u_be));

    audclk_divider #(.LEGACY(1'b1)) i_audclk_divider_legacy (
        .clk(clk), .rst_n(rst_n), .mclk_code(l_mc), .bclk_code(l_bc),
        .mclk_gate_en(l_gate), .mclk_o(l_mo), .mclk_tick(l_mt),
        .bclk_o(l_bo), .bclk_tick(l_bt), .mclk_code_err(l_me), .bclk_code_err(l_be));

    int n_chk = 0;
    int n_fail = 0;

    // Expected ratios from the requirement tables (R2, R4, R5)
    function automatic logic [7:0] ru(logic [3:0] c);
        case (c)
            4'd1: return 8'd1;    4'd2: return 8'd2;    4'd3: return 8'd4;
            4'd4: return 8'd6;    4'd5: return 8'd8;    4'd6: return 8'd12;
            4'd7: return 8'd16;   4'd8: return 8'd24;   4'd9: return 8'd32;
            4'd10: return 8'd48;  4'd11: return 8'd64;  4'd12: return 8'd96;
            4'd13: return 8'd128; 4'd14: return 8'd176; 4'd15: return 8'd192;
            default: return 8'd0;
        endcase
    endfunction

    function automatic logic [7:0] rlb(logic [3:0] c);
        if (c > 4'd5) return 8'd0;
        case (c)
            4'd0: return 8'd2;  4'd1: return 8'd4;  4'd2: return 8'd6;
            4'd3: return 8'd8;  4'd4: return 8'd12; default: return 8'd16;
        endcase
    endfunction

    function automatic logic [7:0] rlm(logic [3:0] c);
        if (c[3]) return 8'd0;
        case (c[2:0])
            3'd0: return 8'd1;  3'd1: return 8'd2;  3'd2: return 8'd4;
            3'd3: return 8'd6;  3'd4: return 8'd8;  3'd5: return 8'd12;
            3'd6: return 8'd16; default: return 8'd24;
        endcase
    endfunction

    // Expected level at a sample point where clk is high (R7, R8)
    function automatic logic lvl(logic run, logic [7:0] rat, logic [7:0] cnt);
        if (!run) return 1'b0;
        if (rat == 8'd1) return 1'b1;
        return cnt < (rat >> 1);
    endfunction

    // Reference divider state
    logic um_run, ub_run, lm_run, lb_run;
    logic [7:0] um_rat, um_cnt, ub_rat, ub_cnt, lm_rat, lm_cnt, lb_rat, lb_cnt;
    logic ue_m, ue_b, le_m, le_b;

    // One counting step of an ideal divider (R9, R12, R3)
    task automatic step(inout logic run, inout logic [7:0] rat, inout logic [7:0] cnt,
                        input logic en, input logic [7:0] req);
        if (en) begin
            if (!run || cnt == rat - 8'd1) begin
                cnt = 8'd0;
                run = (req != 8'd0);
                rat = req;
            end else begin
                cnt = cnt + 8'd1;
            end
        end
    endtask

    always @(posedge clk) begin : ref_model
        logic lm_tick_pre;
        if (!rst_n) begin
            um_run = 0; ub_run = 0; lm_run = 0; lb_run = 0;
            um_rat = 0; um_cnt = 0; ub_rat = 0; ub_cnt = 0;
            lm_rat = 0; lm_cnt = 0; lb_rat = 0; lb_cnt = 0;
            ue_m = 0; ue_b = 0; le_m = 0; le_b = 0;
        end else begin
            lm_tick_pre = lm_run && lm_cnt == 8'd0;
            ue_m = (ru(u_mc) == 0);  ue_b = (ru(u_bc) == 0);
            le_m = (rlm(l_mc) == 0); le_b = (rlb(l_bc) == 0);
            step(um_run, um_rat, um_cnt, 1'b1, ru(u_mc));
            step(ub_run, ub_rat, ub_cnt, 1'b1, ru(u_bc));
            step(lm_run, lm_rat, lm_cnt, 1'b1, rlm(l_mc));
            step(lb_run, lb_rat, lb_cnt, lm_tick_pre, rlb(l_bc));
        end
    end

    task automatic chk(string req, logic [5:0] act, logic [5:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic chkv(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Advance one cycle and compare both copies against the reference
    task automatic cyc(string req);
        logic lmt;
        @(posedge clk);
        #1;
        lmt = lm_run && lm_cnt == 8'd0;
        chk(req, {u_mo, u_mt, u_bo, u_bt, u_me, u_be},
            {u_gate && lvl(um_run, um_rat, um_cnt), um_run && um_cnt == 8'd0,
             lvl(ub_run, ub_rat, ub_cnt), ub_run && ub_cnt == 8'd0, ue_m, ue_b});
        chk(req, {l_mo, l_mt, l_bo, l_bt, l_me, l_be},
            {l_gate && lvl(lm_run, lm_rat, lm_cnt), lmt,
             lvl(lb_run, lb_rat, lb_cnt), lb_run && lb_cnt == 8'd0 && lmt, le_m, le_b});
    endtask

    task automatic wait_tick(string req, bit leg);
        do cyc(req); while (!(leg ? l_bt : u_bt));
    endtask

    task automatic gap(string req, bit leg, output int g);
        g = 0;
        do begin cyc(req); g++; end while (!(leg ? l_bt : u_bt));
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int g;
        int h;
        int t;
        void'($urandom(32'd20240611));

        // R1: outputs quiet while reset is held
        repeat (3) cyc("R1");
        chk("R1", {u_mo, u_mt, u_bo, u_bt, u_me, u_be, l_mt, l_bt}, 8'h00);
        rst_n = 1'b1;

        // R12: first edge after reset starts the default bit clock with a tick
        cyc("R12");
        chkv("R12", int'(u_bt), 1);

        // R2: code 5 gives an 8-cycle bit period; R6: legacy 1 x 8
        wait_tick("R2", 1'b0);
        gap("R2", 1'b0, g);     chkv("R2", g, 8);
        wait_tick("R6", 1'b1);
        gap("R6", 1'b1, g);     chkv("R6", g, 8);

        // R8: divide-1 master clock follows clk in both phases
        cyc("R8");
        chkv("R8", int'(u_mo), 1);
        chkv("R8", int'(u_mt), 1);
        #2.5;
        chkv("R8", int'(u_mo), 0);

        // R7: 50% duty over one 8-cycle bit period
        wait_tick("R7", 1'b0);
        h = int'(u_bo);
        repeat (7) begin cyc("R7"); h += int'(u_bo); end
        chkv("R7", h, 4);

        // R6: legacy master divide 2 doubles the bit period
        l_mc = 4'd1;
        wait_tick("R6", 1'b1);
        wait_tick("R6", 1'b1);
        gap("R6", 1'b1, g);     chkv("R6", g, 16);

        // R9: change to code 6 right after a tick keeps this period at 8
        wait_tick("R9", 1'b0);
        u_bc = 4'd6;
        gap("R9", 1'b0, g);     chkv("R9", g, 8);
        gap("R9", 1'b0, g);     chkv("R9", g, 12);

        // R3, R11: code 0 flags an error and stops after the wrap
        wait_tick("R3", 1'b0);
        u_bc = 4'd0;
        cyc("R11");
        chkv("R11", int'(u_be), 1);
        repeat (12) cyc("R3");
        h = 0;
        repeat (20) begin cyc("R3"); h += int'(u_bo) + int'(u_bt); end
        chkv("R3", h, 0);
        u_bc = 4'd4;
        cyc("R11");
        chkv("R11", int'(u_be), 0);
        chkv("R12", int'(u_bt), 1);
        gap("R2", 1'b0, g);     chkv("R2", g, 6);

        // R4: legacy bit codes above 5 are invalid
        l_bc = 4'd6;
        repeat (2) cyc("R4");
        chkv("R4", int'(l_be), 1);
        repeat (40) cyc("R4");
        h = 0;
        repeat (30) begin cyc("R4"); h += int'(l_bt) + int'(l_bo); end
        chkv("R4", h, 0);
        l_bc = 4'd5;

        // R5: legacy master code with bit 3 set is invalid
        l_mc = 4'd8;
        repeat (2) cyc("R5");
        chkv("R5", int'(l_me), 1);
        repeat (4) cyc("R5");
        h = 0;
        repeat (20) begin cyc("R5"); h += int'(l_mt) + int'(l_bt); end
        chkv("R5", h, 0);
        l_mc = 4'd0;

        // R10: gate off masks the pin, tick keeps running
        u_mc = 4'd3;
        u_gate = 1'b0;
        h = 0; t = 0;
        repeat (20) begin cyc("R10"); h += int'(u_mo); t += int'(u_mt); end
        chkv("R10", h, 0);
        chkv("R10", t, 5);
        u_gate = 1'b1;

        // Random codes and gate; every cycle compared with the reference
        for (int i = 0; i < 3000; i++) begin
            if ($urandom % 24 == 0) u_mc = 4'($urandom);
            if ($urandom % 24 == 0) u_bc = 4'($urandom);
            if ($urandom % 24 == 0) l_mc = 4'($urandom);
            if ($urandom % 24 == 0) l_bc = 4'($urandom);
            if ($urandom % 32 == 0) u_gate = ~u_gate;
            if ($urandom % 32 == 0) l_gate = ~l_gate;
            cyc("R7");
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule